// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope analog-to-digital converter with automatic zero and automatic polarity. It walks each conversion through six ordered segments: a zeroing phase, an offset measurement, a second zeroing phase, an upward integration of the unknown input, a down-ramp that uses up the measured offset, and a fixed down-ramp window in which the reading is counted. It drives the analog switch controls and reads back a single comparator. The integrator, the comparator and the oscillator sit outside the block.

The reading is counted directly in BCD: a half digit of two bits above three full decades. The count saturates at 2000 when the comparator never trips. At the end of every conversion the block emits a half-clock end-of-conversion pulse. The result latches take the new reading, polarity, overrange and underrange only if a rising edge on the display-update input was seen before the ramp-down started. Wiring the update input to the end-of-conversion output refreshes the latches on every conversion. Splitting the reading into display digits is left to a separate block.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset, az_sw is 1, in_sw and ref_sw are 0, eoc is 0, res_bcd is 0, res_pos is 1, res_over and res_under are 0, and ref_neg is 1.
- R2: Only one switch control is high at a time. az_sw stays high for AZ_CLKS cycles in segments 1 and 3. All switches are low in segment 2. in_sw stays high for INT_CLKS cycles in segment 4. ref_sw goes high in the cycle in_sw falls and stays high through segments 5 and 6.
- R3: Segment 2 stores as the offset the number of clock edges it counted before the synchronized comparator was seen high. Segment 5 then lasts exactly that many cycles before the counting window opens.
- R4: res_pos takes the synchronized comparator level on the last edge of segment 4 (1 = positive input). During a conversion, ref_neg equals the polarity found by the previous conversion, and it is 1 after reset.
- R5: The reading is the number of window edges in segment 6 before the first synchronized comparator trip. It is presented on res_bcd as thousands in [13:12], hundreds in [11:8], tens in [7:4] and units in [3:0], and each decade is 0 to 9.
- R6: If the comparator does not trip within the window, the reading saturates at 2000 (res_bcd = 14'h2000). res_over is 1 exactly when the reading is above 1999.
- R7: res_under is 1 exactly when the reading is below UR_LIMIT (180): a reading of 179 sets it and a reading of 180 clears it.
- R8: Each conversion ends with one eoc pulse that rises on the clock edge closing segment 6 and lasts half a clock period. Segment 1 of the next conversion starts on that same edge.
- R9: The result latches and res_pos load at the end of a conversion only if a rising du_in edge arrived during segments 1 to 4 of that conversion. An edge during segments 5 and 6 leaves them unchanged. With du_in tied to eoc, every conversion after the first tied one updates.
- R10: If the comparator has not tripped after OFS_MAX edges in segment 2, segment 3 starts anyway with an offset of OFS_MAX-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Comparator output (1 = tripped, or positive at the end of integration) |
| du_in | input | 1 | Display-update request, rising edge |
| az_sw | output | 1 | Auto-zero switch: integrator shorted, offset capacitor charging |
| in_sw | output | 1 | Integrate the unknown input |
| ref_sw | output | 1 | Integrate the reference (down-ramp) |
| ref_neg | output | 1 | Reference polarity select (1 = reference applied negative) |
| eoc | output | 1 | End-of-conversion pulse, half a clock wide |
| res_bcd | output | 14 | Latched reading in BCD |
| res_pos | output | 1 | Latched polarity, 1 = positive |
| res_over | output | 1 | Latched overrange flag |
| res_under | output | 1 | Latched underrange flag |

## Verification
The assertions assume a clean reset at the start, and that the comparator and update inputs are well-defined levels, so the result latches and the reference select change only on the end-of-conversion edge. The bench changes cmp_in only on falling clock edges. It holds cmp_in low at the start of segments 2 and 6 and places every trip well inside its segment, so each segment begins from an untripped comparator. It drives du_in itself only while du_in is not tied to eoc, and each pulse lands clearly inside segments 3 or 6.

// File: rtl/dual_slope_seq.sv
module dual_slope_seq #(
  parameter int AZ_CLKS  = 4000,
  parameter int OFS_MAX  = 800,
  parameter int INT_CLKS = 4000,
  parameter int WIN_CLKS = 4000,
  parameter int UR_LIMIT = 180
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmp_in,
  input  logic        du_in,
  output logic        az_sw,
  output logic        in_sw,
  output logic        ref_sw,
  output logic        ref_neg,
  output logic        eoc,
  output logic [13:0] res_bcd,
  output logic        res_pos,
  output logic        res_over,
  output logic        res_under
);
  localparam int M1 = (AZ_CLKS > INT_CLKS) ? AZ_CLKS : INT_CLKS;
  localparam int M2 = (M1 > WIN_CLKS) ? M1 : WIN_CLKS;
  localparam int M3 = (M2 > OFS_MAX) ? M2 : OFS_MAX;
  localparam int TW = $clog2(M3 + 1);
  localparam int OW = $clog2(OFS_MAX + 1);

  typedef enum logic [2:0] {S_AZ1, S_OFS, S_AZ2, S_INT, S_RMP, S_WIN} seg_t;

  seg_t          seg;
  logic [TW-1:0] tmr;
  logic [OW-1:0] ofs;
  logic          cmp_s1, cmp_s;
  logic [1:0]    th;
  logic [3:0]    hu, te, un;
  logic [1:0]    nx_th;
  logic [3:0]    nx_hu, nx_te, nx_un;
  logic          done, sign_now, prev_pos, armed;
  logic          eoc_r, eoc_h;
  logic          du_tog, du_s1, du_s2, du_s3;
  logic [11:0]   cnt_bin;

  wire early    = (seg == S_AZ1) || (seg == S_OFS) || (seg == S_AZ2) || (seg == S_INT);
  wire du_edge  = du_s2 ^ du_s3;
  wire sat      = (th == 2'd2);
  wire win_end  = (seg == S_WIN) && (tmr == TW'(WIN_CLKS - 1));

  assign az_sw   = (seg == S_AZ1) || (seg == S_AZ2);
  assign in_sw   = (seg == S_INT);
  assign ref_sw  = (seg == S_RMP) || (seg == S_WIN);
  assign ref_neg = prev_pos;
  assign eoc     = eoc_r & ~eoc_h;

  assign cnt_bin = {10'd0, th} * 12'd1000 + {8'd0, hu} * 12'd100
                 + {8'd0, te} * 12'd10 + {8'd0, un};

  always_comb begin
    nx_th = th; nx_hu = hu; nx_te = te; nx_un = un;
    if (un != 4'd9) nx_un = un + 4'd1;
    else begin
      nx_un = 4'd0;
      if (te != 4'd9) nx_te = te + 4'd1;
      else begin
        nx_te = 4'd0;
        if (hu != 4'd9) nx_hu = hu + 4'd1;
        else begin
          nx_hu = 4'd0;
          nx_th = th + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_s1 <= 1'b0;
      cmp_s  <= 1'b0;
    end else begin
      cmp_s1 <= cmp_in;
      cmp_s  <= cmp_s1;
    end

  always_ff @(posedge du_in or negedge rst_n)
    if (!rst_n) du_tog <= 1'b0;
    else        du_tog <= ~du_tog;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      du_s1 <= 1'b0;
      du_s2 <= 1'b0;
      du_s3 <= 1'b0;
    end else begin
      du_s1 <= du_tog;
      du_s2 <= du_s1;
      du_s3 <= du_s2;
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) eoc_h <= 1'b0;
    else        eoc_h <= eoc_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seg      <= S_AZ1;
      tmr      <= '0;
      ofs      <= '0;
      th       <= '0;
      hu       <= '0;
      te       <= '0;
      un       <= '0;
      done     <= 1'b0;
      sign_now <= 1'b1;
      prev_pos <= 1'b1;
      armed    <= 1'b0;
      eoc_r    <= 1'b0;
      res_bcd  <= '0;
      res_pos  <= 1'b1;
      res_over <= 1'b0;
      res_under <= 1'b0;
    end else begin
      eoc_r <= 1'b0;
      if (du_edge && early) armed <= 1'b1;
      case (seg)
        S_AZ1, S_AZ2: begin
          if (tmr == TW'(AZ_CLKS - 1)) begin
            seg <= (seg == S_AZ1) ? S_OFS : S_INT;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_OFS: begin
          if (cmp_s || tmr == TW'(OFS_MAX - 1)) begin
            ofs <= OW'(tmr);
            seg <= S_AZ2;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_INT: begin
          if (tmr == TW'(INT_CLKS - 1)) begin
            sign_now <= cmp_s;
            seg  <= (ofs == '0) ? S_WIN : S_RMP;
            tmr  <= '0;
            th   <= '0;
            hu   <= '0;
            te   <= '0;
            un   <= '0;
            done <= 1'b0;
          end else tmr <= tmr + 1'b1;
        end
        S_RMP: begin
          if (tmr == TW'(ofs) - 1'b1) begin
            seg <= S_WIN;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_WIN: begin
          if (win_end) begin
            if (armed) begin
              res_bcd   <= {th, hu, te, un};
              res_pos   <= sign_now;
              res_over  <= (cnt_bin > 12'd1999);
              res_under <= (cnt_bin < 12'(UR_LIMIT));
            end
            prev_pos <= sign_now;
            armed    <= 1'b0;
            eoc_r    <= 1'b1;
            seg      <= S_AZ1;
            tmr      <= '0;
          end else begin
            tmr <= tmr + 1'b1;
            if (cmp_s) done <= 1'b1;
            else if (!done && !sat) begin
              th <= nx_th;
              hu <= nx_hu;
              te <= nx_te;
              un <= nx_un;
            end
          end
        end
        default: seg <= S_AZ1;
      endcase
    end
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        az_sw,
  input logic        in_sw,
  input logic        ref_sw,
  input logic        ref_neg,
  input logic        eoc_r,
  input logic [13:0] res_bcd,
  input logic        res_over,
  input logic        res_under
);
  AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({az_sw, in_sw, ref_sw})); // R2
  AST_INPUT_THEN_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sw) |-> ref_sw); // R2
  AST_ZERO_THEN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sw) |-> $past(az_sw)); // R2
  AST_RESULT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (res_bcd != $past(res_bcd)) |-> eoc_r); // R9
  AST_REFSEL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_neg != $past(ref_neg)) |-> eoc_r); // R4
  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
    res_bcd[11:8] <= 4'd9 && res_bcd[7:4] <= 4'd9 && res_bcd[3:0] <= 4'd9); // R5
  AST_OVER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    res_over == (res_bcd == 14'h2000)); // R6
  AST_UNDER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    res_under |-> (res_bcd[13:12] == 2'd0 && res_bcd[11:8] <= 4'd1)); // R7
  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_r |=> !eoc_r); // R8
  AST_EOC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_r |-> az_sw); // R8
endmodule

bind dual_slope_seq dual_slope_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .az_sw(az_sw), .in_sw(in_sw), .ref_sw(ref_sw),
  .ref_neg(ref_neg), .eoc_r(eoc_r), .res_bcd(res_bcd), .res_over(res_over),
  .res_under(res_under)
);

// File: tb/dual_slope_seq_test.sv
`timescale 1ns/1ps
module dual_slope_seq_test;
  localparam int AZ  = 60;
  localparam int OFM = 800;
  localparam int INT = 60;
  localparam int WIN = 2100;

  logic clk = 1'b0, rst_n = 1'b0, cmp = 1'b0, du_drv = 1'b0, du_sel = 1'b0;
  logic az_sw, in_sw, ref_sw, ref_neg, eoc, res_pos, res_over, res_under;
  logic [13:0] res_bcd;
  wire du_in = du_sel ? eoc : du_drv;

  int checks = 0, errors = 0;
  int exp_bcd = 0, exp_pos = 1, exp_over = 0, exp_under = 0;
  int prev_sign = 1, tie_armed = 0;

  always #2.5 clk = ~clk;

  dual_slope_seq #(.AZ_CLKS(AZ), .OFS_MAX(OFM), .INT_CLKS(INT), .WIN_CLKS(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp), .du_in(du_in), .az_sw(az_sw),
    .in_sw(in_sw), .ref_sw(ref_sw), .ref_neg(ref_neg), .eoc(eoc),
    .res_bcd(res_bcd), .res_pos(res_pos), .res_over(res_over), .res_under(res_under));

  function automatic int to_bcd(int n);
    return ((n / 1000) << 12) | (((n / 100) % 10) << 8) | (((n / 10) % 10) << 4) | (n % 10);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_conv(int j, int sign, int n, int mode, string tag);
    int cnt, off, res, upd;
    real t0, w;
    cmp = 1'b0;
    du_sel = (mode == 3);
    do @(negedge clk); while (az_sw);
    if (j >= 0) begin
      repeat (j) @(negedge clk);
      cmp = 1'b1;
    end
    do @(negedge clk); while (!az_sw);
    cmp = 1'b0;
    cnt = 1;
    forever begin
      @(negedge clk);
      if (mode == 1) du_drv = (cnt == 3);
      if (!az_sw) break;
      cnt++;
    end
    chk("R2", "zero phase length", cnt, AZ);
    chk("R2", "input switch after zero", in_sw, 1);
    cmp = sign[0];
    cnt = 1;
    forever begin
      @(negedge clk);
      if (!in_sw) break;
      cnt++;
    end
    chk("R2", "integrate length", cnt, INT);
    chk("R2", "reference switch after integrate", ref_sw, 1);
    chk("R4", "reference polarity from previous", ref_neg, prev_sign);
    cmp = 1'b0;
    off = (j < 0) ? OFM - 1 : j + 2;
    if (n <= 1999) begin
      repeat (n + off - 2) @(negedge clk);
      cmp = 1'b1;
    end
    if (mode == 2) begin
      @(negedge clk); du_drv = 1'b1;
      @(negedge clk); du_drv = 1'b0;
    end
    @(posedge eoc); t0 = $realtime;
    @(negedge eoc); w = $realtime - t0;
    chk("R8", "eoc width x10 ns", int'(w * 10.0), 25);
    @(negedge clk); #1;
    chk("R8", "new conversion starts", az_sw, 1);
    res = (n > 1999) ? 2000 : n;
    upd = (mode == 1) || (tie_armed != 0);
    if (upd) begin
      exp_bcd = to_bcd(res);
      exp_pos = sign;
      exp_over = (res > 1999);
      exp_under = (res < 180);
    end
    chk(tag, "reading", int'(res_bcd), exp_bcd);
    chk("R4", "polarity", res_pos, exp_pos);
    chk("R6", "overrange", res_over, exp_over);
    chk("R7", "underrange", res_under, exp_under);
    prev_sign = sign;
    tie_armed = (mode == 3);
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "az_sw", az_sw, 1);
    chk("R1", "in_sw/ref_sw", {in_sw, ref_sw}, 0);
    chk("R1", "eoc", eoc, 0);
    chk("R1", "res_bcd", int'(res_bcd), 0);
    chk("R1", "flags", {res_pos, res_over, res_under}, 3'b100);
    chk("R1", "ref_neg", ref_neg, 1);
    @(negedge clk); rst_n = 1'b1;
    run_conv(3, 1, 1234, 1, "R5");
    run_conv(0, 0, 1999, 1, "R5");
    run_conv(5, 1, 5000, 1, "R6");
    run_conv(2, 1, 179, 1, "R7");
    run_conv(2, 0, 180, 1, "R7");
    run_conv(4, 1, 500, 2, "R9");
    run_conv(4, 0, 42, 0, "R9");
    run_conv(-1, 1, 777, 1, "R10");
    run_conv(20, 0, 0, 1, "R3");
    run_conv(9, 1, 321, 3, "R9");
    run_conv(1, 0, 1500, 3, "R9");
    run_conv(6, 1, 9, 3, "R9");
    run_conv(6, 1, 88, 1, "R5");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule